// File: doc/BRIEF.md
# Three-in-a-Row Ones Detector

This block watches a single serial bit, sampled on every rising clock edge, and raises its flag once that bit has been 1 on at least three back-to-back edges. The flag stays high for as long as the bit keeps reading 1. A single 0 sample sends the machine back to its idle state. The output is a Moore output: it is decoded from the stored state alone, so it can change only at a clock edge.

The state is held in two bits, `{hi, lo}`, and the encoding is fixed: 00 means no ones seen, 01 means one, 10 means two, and 11 means three or more. A compile-time parameter chooses how the two state bits are built. The choices are plain D registers, a pair of JK flip-flops, or a pair of T flip-flops, and each choice has its own excitation equations. All three builds must follow exactly the same state and output sequence on every cycle. A synchronous active-high reset returns the state to idle. The current state is brought out on a port so that the three builds can be compared cycle by cycle.

Top module: `run3_detector`

## Requirements
- R1: `z_out` is 1 in a cycle exactly when `x_in` was 1 on each of the last three or more rising edges since reset.
- R2: A rising edge that samples `x_in` = 0 (with reset low) makes `state_out` 2'b00 and `z_out` 0 in the following cycle, whatever the earlier state was.
- R3: With reset low, each edge that samples `x_in` = 1 moves `state_out` one step along 2'b00 → 2'b01 → 2'b10 → 2'b11.
- R4: While `state_out` is 2'b11, further edges that sample `x_in` = 1 leave it at 2'b11 and keep `z_out` at 1.
- R5: An edge that samples `rst` = 1 makes `state_out` 2'b00 and `z_out` 0 in the next cycle. Reset takes priority even when `x_in` = 1 and the state is 2'b11.
- R6: `z_out` depends only on the stored state. A change on `x_in` between clock edges leaves `z_out` unchanged until the next edge.
- R7: The STYLE parameter selects the build: 0 gives D registers, 1 gives JK flip-flops, 2 gives T flip-flops. All builds produce the same `state_out` and `z_out` on every cycle for the same inputs. Each JK or T flip-flop holds its value when its inputs are inactive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 1 | Serial bit under observation |
| state_out | output | 2 | Run-count state: 00 idle, 01 one, 10 two, 11 three or more |
| z_out | output | 1 | High while the run of ones is at least three long |

## Verification
Two functions can fall in the same cycle. One is the reset clearing the state; the other is a saturated run holding at 11 while `x_in` stays 1. The bench provokes this by asserting reset in the middle of a long run of ones and keeping `x_in` high during the reset, then checks that all three builds show 00 in the next cycle. A second collision is a 0 sample arriving on the very edge that would complete a run of three. The bench judges this against a saturating run counter and checks that all three builds fall back to 00 together, instead of reaching 11.

// File: rtl/run3_pkg.sv
package run3_pkg;

    typedef enum logic [1:0] {
        FLOP_D  = 2'd0,
        FLOP_JK = 2'd1,
        FLOP_T  = 2'd2
    } flop_style_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } run_state_t;

    typedef struct packed {
        logic j;
        logic k;
    } jk_drive_t;

    localparam run_state_t ST_IDLE = 2'b00;
    localparam run_state_t ST_SAT  = 2'b11;

    function automatic run_state_t d_next(input logic x, input run_state_t s);
        run_state_t n;
        n.hi = x & (s.lo | s.hi);
        n.lo = x & (~s.lo | s.hi);
        return n;
    endfunction

    function automatic jk_drive_t jk_hi_drive(input logic x, input run_state_t s);
        jk_drive_t d;
        d.j = x & s.lo;
        d.k = ~x;
        return d;
    endfunction

    function automatic jk_drive_t jk_lo_drive(input logic x, input run_state_t s);
        jk_drive_t d;
        d.j = x;
        d.k = ~x | ~s.hi;
        return d;
    endfunction

    function automatic logic t_hi_drive(input logic x, input run_state_t s);
        return (~x & s.hi) | (x & ~s.hi & s.lo);
    endfunction

    function automatic logic t_lo_drive(input logic x, input run_state_t s);
        return (~x & s.lo) | (x & ~s.lo) | (x & ~s.hi & s.lo);
    endfunction

    function automatic logic sat_decode(input run_state_t s);
        return s.hi & s.lo;
    endfunction

endpackage

// File: rtl/run3_jk_flop.sv
module run3_jk_flop (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end

    // R7: an inactive JK pair keeps the bit
    p_jk_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!j && !k) |=> $stable(q));
    // R7: both active flips the bit
    p_jk_toggle_r7: assert property (@(posedge clk) disable iff (rst)
        (j && k) |=> (q != $past(q)));
endmodule

// File: rtl/run3_t_flop.sv
module run3_t_flop (
    input  logic clk,
    input  logic rst,
    input  logic t,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (t) begin
            q <= ~q;
        end
    end

    // R7: idle toggle input keeps the bit
    p_t_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !t |=> $stable(q));
endmodule

// File: rtl/run3_state.sv
module run3_state
    import run3_pkg::*;
#(
    parameter flop_style_e STYLE = FLOP_D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       x,
    output run_state_t st
);
    generate
        if (STYLE == FLOP_D) begin : g_d
            always_ff @(posedge clk) begin
                if (rst) st <= ST_IDLE;
                else     st <= d_next(x, st);
            end
        end else if (STYLE == FLOP_JK) begin : g_jk
            jk_drive_t dh;
            jk_drive_t dl;
            logic      q_hi;
            logic      q_lo;
            assign dh = jk_hi_drive(x, st);
            assign dl = jk_lo_drive(x, st);
            run3_jk_flop u_hi (.clk(clk), .rst(rst), .j(dh.j), .k(dh.k), .q(q_hi));
            run3_jk_flop u_lo (.clk(clk), .rst(rst), .j(dl.j), .k(dl.k), .q(q_lo));
            assign st = run_state_t'({q_hi, q_lo});
        end else begin : g_t
            logic t_hi;
            logic t_lo;
            logic q_hi;
            logic q_lo;
            assign t_hi = t_hi_drive(x, st);
            assign t_lo = t_lo_drive(x, st);
            run3_t_flop u_hi (.clk(clk), .rst(rst), .t(t_hi), .q(q_hi));
            run3_t_flop u_lo (.clk(clk), .rst(rst), .t(t_lo), .q(q_lo));
            assign st = run_state_t'({q_hi, q_lo});
        end
    endgenerate
endmodule

// File: rtl/run3_detector.sv
module run3_detector
    import run3_pkg::*;
#(
    parameter flop_style_e STYLE = FLOP_D
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       x_in,
    output logic [1:0] state_out,
    output logic       z_out
);
    run_state_t cur;

    run3_state #(.STYLE(STYLE)) u_state (
        .clk (clk),
        .rst (rst),
        .x   (x_in),
        .st  (cur)
    );

    assign state_out = cur;
    assign z_out     = sat_decode(cur);

    // R1: a high flag needs three sampled ones behind it
    p_flag_needs_run_r1: assert property (@(posedge clk) disable iff (rst)
        z_out |-> ($past(x_in) && $past(x_in, 2) && $past(x_in, 3)));
    // R2: a zero sample clears the count
    p_zero_clears_r2: assert property (@(posedge clk) disable iff (rst)
        !x_in |=> (state_out == 2'b00 && !z_out));
    // R3: a one sample below saturation advances by one step
    p_step_up_r3: assert property (@(posedge clk) disable iff (rst)
        (x_in && state_out != 2'b11) |=> (state_out == 2'($past(state_out) + 2'd1)));
    // R4: saturation holds under continued ones
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (x_in && state_out == 2'b11) |=> (state_out == 2'b11 && z_out));
    // R5: reset wins over any input
    p_reset_idle_r5: assert property (@(posedge clk)
        rst |=> (state_out == 2'b00 && !z_out));
    // R6: the flag moves only together with the state
    p_flag_follows_state_r6: assert property (@(posedge clk) disable iff (rst)
        $stable(state_out) |-> $stable(z_out));
endmodule

// File: tb/run3_detector_bench.sv
module run3_detector_bench;
    import run3_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic [1:0] st_d, st_jk, st_t;
    logic z_d, z_jk, z_t;

    int checks = 0;
    int fails  = 0;
    int model  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    run3_detector #(.STYLE(FLOP_D))  u_run3_detector    (.clk(clk), .rst(rst), .x_in(x_in), .state_out(st_d),  .z_out(z_d));
    run3_detector #(.STYLE(FLOP_JK)) u_run3_detector_jk (.clk(clk), .rst(rst), .x_in(x_in), .state_out(st_jk), .z_out(z_jk));
    run3_detector #(.STYLE(FLOP_T))  u_run3_detector_t  (.clk(clk), .rst(rst), .x_in(x_in), .state_out(st_t),  .z_out(z_t));

    function automatic int next_model(input int m, input bit r, input bit x);
        if (r) return 0;
        if (!x) return 0;
        return (m >= 3) ? 3 : m + 1;
    endfunction

    task automatic check_one(input string req, input string who,
                             input logic [1:0] st, input logic z);
        logic [1:0] exp_st;
        logic       exp_z;
        exp_st = 2'(model);
        exp_z  = (model == 3);
        checks++;
        if (st !== exp_st || z !== exp_z) begin
            fails++;
            $display("FAIL %s %s: state=%b z=%b expected state=%b z=%b",
                     req, who, st, z, exp_st, exp_z);
        end
    endtask

    task automatic check_all(input string req);
        check_one(req, "D",  st_d,  z_d);
        check_one(req, "JK", st_jk, z_jk);
        check_one(req, "T",  st_t,  z_t);
    endtask

    // drive at falling edge, sample 5 ns after the rising edge
    task automatic step(input bit r, input bit x, input string req);
        @(negedge clk);
        rst  = r;
        x_in = x;
        model = next_model(model, r, x);
        @(posedge clk);
        #5;
        check_all(req);
    endtask

    // R6: wiggle x mid-cycle, flag must not move
    task automatic moore_probe();
        logic zd0, zj0, zt0;
        @(negedge clk);
        zd0 = z_d; zj0 = z_jk; zt0 = z_t;
        x_in = ~x_in;
        #2;
        checks++;
        if (z_d !== zd0 || z_jk !== zj0 || z_t !== zt0) begin
            fails++;
            $display("FAIL R6: z=%b%b%b expected %b%b%b", z_d, z_jk, z_t, zd0, zj0, zt0);
        end
        x_in = ~x_in;
    endtask

    initial begin
        void'($urandom(32'd20241));
        // R5: reset state
        step(1'b1, 1'b1, "R5");
        step(1'b1, 1'b0, "R5");
        // R3: climb 0->1->2->3, R1 flag rises on third one
        step(1'b0, 1'b1, "R3");
        step(1'b0, 1'b1, "R3");
        moore_probe();
        step(1'b0, 1'b1, "R1");
        // R4: hold saturation
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, "R4");
        moore_probe();
        // R2: drop out of saturation
        step(1'b0, 1'b0, "R2");
        // run of exactly 2 then zero: never flags (R1/R2)
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R2");
        // run of exactly 3
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, "R1");
        step(1'b0, 1'b0, "R2");
        // reset during saturated run with x high (R5 vs R4)
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, "R4");
        step(1'b1, 1'b1, "R5");
        step(1'b0, 1'b1, "R3");
        // random mix, all builds against the model (R7)
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 97) == 0, ($urandom % 4) != 0, "R7");
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule